// File: doc/BRIEF.md
# UDP Socket Bring-up and Service Sequencer

This block controls an external network offload controller that runs the TCP/IP protocols in hardware. After reset it holds the controller in reset and waits for a settle time. It then writes the controller's global settings and network identity, sizes the socket buffers, and opens one socket in UDP mode. Every step is a single-byte register access on a request/acknowledge port. Separate logic carries out the actual bus cycles.

Once the socket is open, the sequencer loops on three things. It closes the socket when asked. It starts a transmit when asked. Otherwise it polls the controller's received-byte count. Copying payload bytes is done by a separate buffer-transfer engine. The sequencer hands that engine a job descriptor with direction and length, then waits for the engine to report completion. It then writes the matching socket command. After a send, it polls the command register until the command register reads zero. During that poll it also watches the controller's timeout flag, and a round counter stops the poll if it runs too long. Network values come from module parameters and are written most significant byte first.

Both outward paths use valid/ready semantics. `reg_req` is a valid: once raised, the address, direction and write data stay constant until a cycle with `reg_ack` high, and the access completes in that cycle. `job_valid` likewise holds direction and length constant until `job_ready` is seen. The far side may stall either path for any number of cycles.

Top module: `udp_sock_seq`

## Requirements
- R1: `chip_rst_n` is low from reset and for at least RST_CYC clocks after `rst_n` is released. No `reg_req` is raised while `chip_rst_n` is low, and the first access starts no sooner than SETTLE_CYC clocks after `chip_rst_n` rises.
- R2: While `reg_req` is high without `reg_ack`, `reg_addr`, `reg_we` and `reg_wdata` remain unchanged in the next cycle and `reg_req` stays high. An access completes only in a cycle with both signals high.
- R3: The first 25 writes form three groups, in this order:
  - Basic settings: mode at 0x00, interrupt mask at 0x01, retry time at 0x02–0x03, retry count at 0x04.
  - Network settings: gateway at 0x08–0x0B, MAC at 0x0C–0x11, subnet mask at 0x12–0x15, local IP at 0x16–0x19.
  - Buffer sizing: receive size at 0x1A, transmit size at 0x1B.
  Every multi-byte value is written most significant byte first, to ascending addresses.
- R4: The socket is brought up with four more writes: 0x02 (UDP) to socket mode 0x40, the port to 0x44 then 0x45 (high byte first), and 0x01 (OPEN) to the socket command register 0x41. `sock_open` then goes high.
- R5: While idle, the sequencer reads the received-byte count, high byte at 0x46 and low byte at 0x47. A zero count raises no job, and polling continues.
- R6: A non-zero count raises `job_valid` with `job_dir`=0 and `job_len` equal to the count. The job is held stable until `job_ready`. After `job_done`, 0x40 (RECV) is written to 0x41.
- R7: `tx_start` seen while idle raises a job with `job_dir`=1 and `job_len`=`tx_len`. After `job_done`, 0x20 (SEND) is written to 0x41, and 0x41 is then polled until it reads zero. `tx_done` then pulses for exactly one cycle.
- R8: While 0x41 reads non-zero, the interrupt register 0x42 is read. If bit 3 is set, `err_timeout` is set and stays set until reset, no `tx_done` is given, and polling for received data resumes.
- R9: If 0x42 is read WD_LIMIT+1 times in one send poll without bit 3 being set, `err_stall` is set and stays set until reset, and the sequencer returns to idle.
- R10: `close_req` seen while idle writes 0x10 (CLOSE) to 0x41. `sock_closed` then goes high and `sock_open` goes low. No further register access takes place until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chip_rst_n | output | 1 | Reset to the offload controller, active low |
| reg_req | output | 1 | Register access valid |
| reg_we | output | 1 | 1 = write, 0 = read |
| reg_addr | output | ADDR_W | Register byte address |
| reg_wdata | output | 8 | Write data |
| reg_ack | input | 1 | Access accepted and complete |
| reg_rdata | input | 8 | Read data, valid with `reg_ack` |
| job_valid | output | 1 | Transfer job valid |
| job_ready | input | 1 | Transfer engine accepts the job |
| job_dir | output | 1 | 0 = receive copy, 1 = transmit copy |
| job_len | output | LEN_W | Bytes to copy |
| job_done | input | 1 | One-cycle pulse when the copy is finished |
| tx_start | input | 1 | Transmit request, held until the job is raised |
| tx_len | input | LEN_W | Transmit length |
| close_req | input | 1 | Close request, held until `sock_closed` |
| sock_open | output | 1 | Socket open and serviced |
| sock_closed | output | 1 | Socket closed |
| tx_done | output | 1 | One-cycle pulse on send completion |
| err_timeout | output | 1 | Sticky peer/send timeout flag |
| err_stall | output | 1 | Sticky command-poll watchdog flag |

## Verification
The bench attacks the following corner cases:

- **Reset and settle windows.** The bench counts both windows. A sequencer that releases the controller early, or starts programming during the settle time, fails the length checks.
- **Programming order.** The 29 writes are compared one by one against an independently written table. Swapped groups or little-endian bytes show up as a miscompare at a specific index.
- **Zero receive count.** A zero count must not raise a job.
- **Transfer handshake.** The transfer job is stalled under back-pressure. A design that dropped or changed the job before `job_ready` would miss the hold checks.
- **Timeout during a send poll.** The timeout flag must abort the poll without `tx_done`.
- **Watchdog round count.** A never-clearing command is polled for an exactly counted number of interrupt-register reads. An off-by-one watchdog reports the wrong read count.
- **Quiet after close.** The port must stay silent once the socket is closed.

// File: rtl/udp_seq_pkg.sv
package udp_seq_pkg;

  typedef enum logic [3:0] {
    ST_RST, ST_SETTLE, ST_CFG, ST_IDLE, ST_RXC_HI, ST_RXC_LO, ST_JOB,
    ST_JOB_WAIT, ST_CMD, ST_POLL_CMD, ST_POLL_IR, ST_CLOSED
  } seq_state_e;

  // common register offsets
  localparam logic [7:0] A_MODE   = 8'h00;
  localparam logic [7:0] A_IMASK  = 8'h01;
  localparam logic [7:0] A_RTIME  = 8'h02;
  localparam logic [7:0] A_RCOUNT = 8'h04;
  localparam logic [7:0] A_GW     = 8'h08;
  localparam logic [7:0] A_MAC    = 8'h0C;
  localparam logic [7:0] A_MASK   = 8'h12;
  localparam logic [7:0] A_IP     = 8'h16;
  localparam logic [7:0] A_RXSZ   = 8'h1A;
  localparam logic [7:0] A_TXSZ   = 8'h1B;
  // socket register offsets
  localparam logic [7:0] A_SMODE  = 8'h40;
  localparam logic [7:0] A_SCMD   = 8'h41;
  localparam logic [7:0] A_SIRQ   = 8'h42;
  localparam logic [7:0] A_SPORT  = 8'h44;
  localparam logic [7:0] A_SRXCNT = 8'h46;

  localparam logic [7:0] PROTO_UDP = 8'h02;
  localparam logic [7:0] CMD_OPEN  = 8'h01;
  localparam logic [7:0] CMD_CLOSE = 8'h10;
  localparam logic [7:0] CMD_SEND  = 8'h20;
  localparam logic [7:0] CMD_RECV  = 8'h40;
  localparam int         IRQ_TO_BIT = 3;

  localparam int CFG_LEN = 29;
  localparam int CFG_IW  = $clog2(CFG_LEN);

endpackage

// File: rtl/udp_seq_count.sv
module udp_seq_count #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= '0;
    else if (clr)       cnt <= '0;
    else if (en && !hit) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/udp_seq_cfg_rom.sv
module udp_seq_cfg_rom
  import udp_seq_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [7:0]  MODE_VAL = 8'h00,
  parameter logic [7:0]  IMASK    = 8'h00,
  parameter logic [15:0] RTIME    = 16'h07D0,
  parameter logic [7:0]  RCOUNT   = 8'h08,
  parameter logic [31:0] GW       = 32'h0,
  parameter logic [47:0] MAC      = 48'h0,
  parameter logic [31:0] MASK     = 32'h0,
  parameter logic [31:0] IP       = 32'h0,
  parameter logic [7:0]  RXSZ     = 8'h55,
  parameter logic [7:0]  TXSZ     = 8'h55,
  parameter logic [15:0] PORT     = 16'h0
) (
  input  logic [CFG_IW-1:0] idx,
  output logic [ADDR_W-1:0] addr,
  output logic [7:0]        data
);
  logic [7:0] a8;
  int k;

  always_comb begin
    k    = int'(idx);
    a8   = 8'h00;
    data = 8'h00;
    if (k == 0)       begin a8 = A_MODE;            data = MODE_VAL;   end
    else if (k == 1)  begin a8 = A_IMASK;           data = IMASK;      end
    else if (k == 2)  begin a8 = A_RTIME;           data = RTIME[15:8]; end
    else if (k == 3)  begin a8 = A_RTIME + 8'd1;    data = RTIME[7:0]; end
    else if (k == 4)  begin a8 = A_RCOUNT;          data = RCOUNT;     end
    else if (k <= 8)  begin a8 = A_GW + 8'(k - 5);   data = 8'(GW >> (8 * (8 - k)));    end
    else if (k <= 14) begin a8 = A_MAC + 8'(k - 9);  data = 8'(MAC >> (8 * (14 - k)));  end
    else if (k <= 18) begin a8 = A_MASK + 8'(k - 15); data = 8'(MASK >> (8 * (18 - k))); end
    else if (k <= 22) begin a8 = A_IP + 8'(k - 19);  data = 8'(IP >> (8 * (22 - k)));   end
    else if (k == 23) begin a8 = A_RXSZ;            data = RXSZ;       end
    else if (k == 24) begin a8 = A_TXSZ;            data = TXSZ;       end
    else if (k == 25) begin a8 = A_SMODE;           data = PROTO_UDP;  end
    else if (k == 26) begin a8 = A_SPORT;           data = PORT[15:8]; end
    else if (k == 27) begin a8 = A_SPORT + 8'd1;    data = PORT[7:0];  end
    else              begin a8 = A_SCMD;            data = CMD_OPEN;   end
    addr = ADDR_W'(a8);
  end
endmodule

// File: rtl/udp_sock_seq.sv
module udp_sock_seq
  import udp_seq_pkg::*;
#(
  parameter int          ADDR_W     = 16,
  parameter int          LEN_W      = 16,
  parameter int          RST_CYC    = 200,
  parameter int          SETTLE_CYC = 400,
  parameter int          WD_LIMIT   = 1000,
  parameter logic [7:0]  MODE_VAL   = 8'h00,
  parameter logic [7:0]  IMASK      = 8'h01,
  parameter logic [15:0] RTIME      = 16'h07D0,
  parameter logic [7:0]  RCOUNT     = 8'h08,
  parameter logic [31:0] GW         = 32'hC0A8_0001,
  parameter logic [47:0] MAC        = 48'h02_00_00_12_34_56,
  parameter logic [31:0] MASK       = 32'hFFFF_FF00,
  parameter logic [31:0] IP         = 32'hC0A8_0064,
  parameter logic [7:0]  RXSZ       = 8'h55,
  parameter logic [7:0]  TXSZ       = 8'h55,
  parameter logic [15:0] PORT       = 16'h1388
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              chip_rst_n,
  output logic              reg_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [7:0]        reg_wdata,
  input  logic              reg_ack,
  input  logic [7:0]        reg_rdata,
  output logic              job_valid,
  input  logic              job_ready,
  output logic              job_dir,
  output logic [LEN_W-1:0]  job_len,
  input  logic              job_done,
  input  logic              tx_start,
  input  logic [LEN_W-1:0]  tx_len,
  input  logic              close_req,
  output logic              sock_open,
  output logic              sock_closed,
  output logic              tx_done,
  output logic              err_timeout,
  output logic              err_stall
);
  localparam int DLY_MAX = (RST_CYC > SETTLE_CYC) ? RST_CYC : SETTLE_CYC;
  localparam int DLY_W   = $clog2(DLY_MAX + 1);
  localparam int WD_W    = $clog2(WD_LIMIT + 1);

  seq_state_e         state;
  logic [CFG_IW-1:0]  cfg_idx;
  logic [7:0]         rx_hi;
  logic [7:0]         cmd_q;
  logic [ADDR_W-1:0]  rom_addr;
  logic [7:0]         rom_data;
  logic               dly_hit, wd_hit, acc_done;
  logic [DLY_W-1:0]   dly_limit;

  udp_seq_cfg_rom #(
    .ADDR_W(ADDR_W), .MODE_VAL(MODE_VAL), .IMASK(IMASK), .RTIME(RTIME),
    .RCOUNT(RCOUNT), .GW(GW), .MAC(MAC), .MASK(MASK), .IP(IP),
    .RXSZ(RXSZ), .TXSZ(TXSZ), .PORT(PORT)
  ) u_rom (
    .idx(cfg_idx), .addr(rom_addr), .data(rom_data)
  );

  assign dly_limit = (state == ST_RST) ? DLY_W'(RST_CYC) : DLY_W'(SETTLE_CYC);

  udp_seq_count #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n),
    .clr(state == ST_RST && dly_hit),
    .en(state == ST_RST || state == ST_SETTLE),
    .limit(dly_limit), .hit(dly_hit)
  );

  udp_seq_count #(.W(WD_W)) u_wd (
    .clk(clk), .rst_n(rst_n),
    .clr(state == ST_CMD),
    .en(state == ST_POLL_IR && acc_done && !reg_rdata[IRQ_TO_BIT]),
    .limit(WD_W'(WD_LIMIT)), .hit(wd_hit)
  );

  // register access request mux
  always_comb begin
    reg_req   = 1'b0;
    reg_we    = 1'b0;
    reg_addr  = '0;
    reg_wdata = 8'h00;
    unique case (state)
      ST_CFG:      begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = rom_addr; reg_wdata = rom_data; end
      ST_RXC_HI:   begin reg_req = 1'b1; reg_addr = ADDR_W'(A_SRXCNT); end
      ST_RXC_LO:   begin reg_req = 1'b1; reg_addr = ADDR_W'(A_SRXCNT + 8'd1); end
      ST_CMD:      begin reg_req = 1'b1; reg_we = 1'b1; reg_addr = ADDR_W'(A_SCMD); reg_wdata = cmd_q; end
      ST_POLL_CMD: begin reg_req = 1'b1; reg_addr = ADDR_W'(A_SCMD); end
      ST_POLL_IR:  begin reg_req = 1'b1; reg_addr = ADDR_W'(A_SIRQ); end
      default: ;
    endcase
  end

  assign acc_done   = reg_req && reg_ack;
  assign chip_rst_n = (state != ST_RST);
  assign job_valid  = (state == ST_JOB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_RST;
      cfg_idx     <= '0;
      rx_hi       <= 8'h00;
      cmd_q       <= 8'h00;
      job_dir     <= 1'b0;
      job_len     <= '0;
      sock_open   <= 1'b0;
      sock_closed <= 1'b0;
      tx_done     <= 1'b0;
      err_timeout <= 1'b0;
      err_stall   <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      unique case (state)
        ST_RST:    if (dly_hit) state <= ST_SETTLE;
        ST_SETTLE: if (dly_hit) begin state <= ST_CFG; cfg_idx <= '0; end
        ST_CFG: if (acc_done) begin
          if (int'(cfg_idx) == CFG_LEN - 1) begin
            state     <= ST_IDLE;
            sock_open <= 1'b1;
          end else begin
            cfg_idx <= cfg_idx + 1'b1;
          end
        end
        ST_IDLE: begin
          if (close_req) begin
            cmd_q <= CMD_CLOSE;
            state <= ST_CMD;
          end else if (tx_start) begin
            job_dir <= 1'b1;
            job_len <= tx_len;
            state   <= ST_JOB;
          end else begin
            state <= ST_RXC_HI;
          end
        end
        ST_RXC_HI: if (acc_done) begin rx_hi <= reg_rdata; state <= ST_RXC_LO; end
        ST_RXC_LO: if (acc_done) begin
          if ({rx_hi, reg_rdata} != 16'h0000) begin
            job_dir <= 1'b0;
            job_len <= LEN_W'({rx_hi, reg_rdata});
            state   <= ST_JOB;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_JOB:      if (job_ready) state <= ST_JOB_WAIT;
        ST_JOB_WAIT: if (job_done) begin
          cmd_q <= job_dir ? CMD_SEND : CMD_RECV;
          state <= ST_CMD;
        end
        ST_CMD: if (acc_done) begin
          if (cmd_q == CMD_CLOSE) begin
            state       <= ST_CLOSED;
            sock_open   <= 1'b0;
            sock_closed <= 1'b1;
          end else if (cmd_q == CMD_SEND) begin
            state <= ST_POLL_CMD;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_POLL_CMD: if (acc_done) begin
          if (reg_rdata == 8'h00) begin
            tx_done <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            state <= ST_POLL_IR;
          end
        end
        ST_POLL_IR: if (acc_done) begin
          if (reg_rdata[IRQ_TO_BIT]) begin
            err_timeout <= 1'b1;
            state       <= ST_IDLE;
          end else if (wd_hit) begin
            err_stall <= 1'b1;
            state     <= ST_IDLE;
          end else begin
            state <= ST_POLL_CMD;
          end
        end
        ST_CLOSED: state <= ST_CLOSED;
        default:   state <= ST_RST;
      endcase
    end
  end
endmodule

// File: rtl/udp_sock_seq_chk.sv
module udp_sock_seq_chk #(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              chip_rst_n,
  input logic              reg_req,
  input logic              reg_ack,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              job_valid,
  input logic              job_ready,
  input logic              job_dir,
  input logic [LEN_W-1:0]  job_len,
  input logic              tx_done,
  input logic              err_timeout,
  input logic              err_stall,
  input logic              sock_open,
  input logic              sock_closed
);
  AST_NO_ACCESS_IN_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req |-> chip_rst_n); // R1

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_req && !reg_ack |=> reg_req && $stable(reg_addr) && $stable(reg_we) && $stable(reg_wdata)); // R2

  AST_JOB_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    job_valid && !job_ready |=> job_valid && $stable(job_dir) && $stable(job_len)); // R6

  AST_JOB_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(job_valid && reg_req)); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done); // R7

  AST_TIMEOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_timeout |=> err_timeout); // R8

  AST_STALL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_stall |=> err_stall); // R9

  AST_CLOSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sock_closed |=> sock_closed && !sock_open && !reg_req && !job_valid); // R10
endmodule

bind udp_sock_seq udp_sock_seq_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .chip_rst_n(chip_rst_n), .reg_req(reg_req),
  .reg_ack(reg_ack), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .job_valid(job_valid), .job_ready(job_ready), .job_dir(job_dir), .job_len(job_len),
  .tx_done(tx_done), .err_timeout(err_timeout), .err_stall(err_stall),
  .sock_open(sock_open), .sock_closed(sock_closed)
);

// File: tb/udp_sock_seq_test.sv
`timescale 1ns/1ps
module udp_sock_seq_test;
  localparam int RST_CYC = 6, SETTLE_CYC = 4, WD_LIMIT = 5;

  // expected programming sequence {addr, data}
  localparam logic [15:0] EXP [29] = '{
    16'h00_00, 16'h01_01, 16'h02_07, 16'h03_D0, 16'h04_08,
    16'h08_C0, 16'h09_A8, 16'h0A_00, 16'h0B_01,
    16'h0C_02, 16'h0D_00, 16'h0E_00, 16'h0F_12, 16'h10_34, 16'h11_56,
    16'h12_FF, 16'h13_FF, 16'h14_FF, 16'h15_00,
    16'h16_C0, 16'h17_A8, 16'h18_00, 16'h19_64,
    16'h1A_55, 16'h1B_55,
    16'h40_02, 16'h44_13, 16'h45_88, 16'h41_01
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic chip_rst_n, reg_req, reg_we, reg_ack, job_valid, job_ready, job_dir, job_done;
  logic tx_start, close_req, sock_open, sock_closed, tx_done, err_timeout, err_stall;
  logic [15:0] reg_addr, job_len, tx_len;
  logic [7:0]  reg_wdata, reg_rdata;

  always #2.5 clk = ~clk;

  udp_sock_seq #(
    .RST_CYC(RST_CYC), .SETTLE_CYC(SETTLE_CYC), .WD_LIMIT(WD_LIMIT),
    .MODE_VAL(8'h00), .IMASK(8'h01), .RTIME(16'h07D0), .RCOUNT(8'h08),
    .GW(32'hC0A8_0001), .MAC(48'h02_00_00_12_34_56), .MASK(32'hFFFF_FF00),
    .IP(32'hC0A8_0064), .RXSZ(8'h55), .TXSZ(8'h55), .PORT(16'h1388)
  ) uut (.*);

  int nchk = 0, nfail = 0;
  int wcnt = 0, acc_cnt = 0, ir_reads = 0, txd_cnt = 0, busy_cfg = 3, cmd_left = 0;
  bit job_seen = 0;
  logic [15:0] wlog [64];
  logic [15:0] rxcnt = 16'h0000;
  logic [7:0]  ir_val = 8'h00;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // offload controller model, acting on falling edges
  initial begin
    reg_ack = 1'b0; reg_rdata = 8'h00;
    forever begin
      @(negedge clk);
      if (tx_done) txd_cnt++;
      if (job_valid) job_seen = 1;
      if (reg_ack) reg_ack = 1'b0;
      else if (reg_req) begin
        acc_cnt++;
        if (reg_we) begin
          if (wcnt < 64) wlog[wcnt] = {reg_addr[7:0], reg_wdata};
          wcnt++;
          if (reg_addr[7:0] == 8'h41) begin
            cmd_left = busy_cfg;
            if (reg_wdata == 8'h40) rxcnt = 16'h0000;
          end
        end else begin
          case (reg_addr[7:0])
            8'h46: reg_rdata = rxcnt[15:8];
            8'h47: reg_rdata = rxcnt[7:0];
            8'h41: if (cmd_left > 0) begin reg_rdata = 8'h20; cmd_left--; end
                   else reg_rdata = 8'h00;
            8'h42: begin reg_rdata = ir_val; ir_reads++; end
            default: reg_rdata = 8'h00;
          endcase
        end
        reg_ack = 1'b1;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  task automatic run_job(input bit dir, input logic [15:0] len, input string req);
    for (int i = 0; i < 2000 && !job_valid; i++) @(negedge clk);
    chk(job_valid === 1'b1, req, job_valid, 1);
    chk(job_dir === dir, req, job_dir, dir);
    chk(job_len === len, req, job_len, len);
    tx_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(job_valid === 1'b1 && job_len === len, req, {job_valid, job_len}, {1'b1, len});
    job_ready = 1'b1; @(negedge clk); job_ready = 1'b0;
    repeat (3) @(negedge clk);
    job_done = 1'b1; @(negedge clk); job_done = 1'b0;
  endtask

  task automatic wait_write(input int prev);
    for (int i = 0; i < 2000 && wcnt <= prev; i++) @(negedge clk);
  endtask

  initial begin
    int lowc, gap, w0, t0, r0, a0;
    job_ready = 0; job_done = 0; tx_start = 0; close_req = 0; tx_len = 16'h0000;
    repeat (3) @(negedge clk);
    // reset state
    chk(chip_rst_n === 1'b0 && reg_req === 1'b0, "R1", {chip_rst_n, reg_req}, 0);
    chk(sock_open === 1'b0 && job_valid === 1'b0 && err_timeout === 1'b0 && err_stall === 1'b0,
        "R1", {sock_open, job_valid, err_timeout, err_stall}, 0);
    rst_n = 1'b1;
    lowc = 0;
    while (!chip_rst_n && lowc < 1000) begin @(negedge clk); lowc++; end
    chk(lowc >= RST_CYC, "R1", lowc, RST_CYC);
    gap = 0;
    while (!reg_req && gap < 1000) begin @(negedge clk); gap++; end
    chk(gap >= SETTLE_CYC, "R1", gap, SETTLE_CYC);

    for (int i = 0; i < 2000 && !sock_open; i++) @(negedge clk);
    chk(sock_open === 1'b1, "R4", sock_open, 1);
    // vector table: programming sequence
    for (int i = 0; i < 29; i++)
      chk(wlog[i] === EXP[i], (i < 25) ? "R3" : "R4", wlog[i], EXP[i]);
    chk(wcnt == 29, "R4", wcnt, 29);

    // R5: zero receive count raises nothing
    a0 = acc_cnt;
    repeat (60) @(negedge clk);
    chk(!job_seen, "R5", job_seen, 0);
    chk(acc_cnt > a0 + 4, "R5", acc_cnt, a0 + 5);

    // R6: receive job with back-pressure, then RECV
    w0 = wcnt;
    rxcnt = 16'h0105;
    run_job(1'b0, 16'h0105, "R6");
    wait_write(w0);
    chk(wlog[w0] === 16'h41_40, "R6", wlog[w0], 16'h4140);

    // R7: transmit, command busy for three reads
    busy_cfg = 3; t0 = txd_cnt; w0 = wcnt;
    tx_len = 16'h0020; tx_start = 1'b1;
    run_job(1'b1, 16'h0020, "R7");
    wait_write(w0);
    chk(wlog[w0] === 16'h41_20, "R7", wlog[w0], 16'h4120);
    for (int i = 0; i < 500 && txd_cnt == t0; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(txd_cnt == t0 + 1, "R7", txd_cnt, t0 + 1);
    chk(!err_timeout && !err_stall, "R7", {err_timeout, err_stall}, 0);

    // R8: timeout flag during the send poll
    busy_cfg = 1000; ir_val = 8'h08; t0 = txd_cnt;
    tx_len = 16'h0003; tx_start = 1'b1;
    run_job(1'b1, 16'h0003, "R8");
    for (int i = 0; i < 500 && !err_timeout; i++) @(negedge clk);
    chk(err_timeout === 1'b1, "R8", err_timeout, 1);
    repeat (20) @(negedge clk);
    chk(err_timeout === 1'b1 && txd_cnt == t0 && !err_stall, "R8", {err_timeout, err_stall}, 2'b10);

    // R9: command never clears, no timeout flag
    ir_val = 8'h00; busy_cfg = 1000;
    tx_len = 16'h0004; tx_start = 1'b1;
    run_job(1'b1, 16'h0004, "R9");
    r0 = ir_reads;
    for (int i = 0; i < 1000 && !err_stall; i++) @(negedge clk);
    chk(err_stall === 1'b1, "R9", err_stall, 1);
    chk(ir_reads - r0 == WD_LIMIT + 1, "R9", ir_reads - r0, WD_LIMIT + 1);
    chk(txd_cnt == t0, "R9", txd_cnt, t0);

    // R10: close
    w0 = wcnt;
    close_req = 1'b1;
    for (int i = 0; i < 500 && !sock_closed; i++) @(negedge clk);
    close_req = 1'b0;
    chk(sock_closed === 1'b1 && sock_open === 1'b0, "R10", {sock_closed, sock_open}, 2'b10);
    chk(wlog[wcnt-1] === 16'h41_10, "R10", wlog[wcnt-1], 16'h4110);
    a0 = acc_cnt;
    rxcnt = 16'h0009; tx_start = 1'b1;
    repeat (40) @(negedge clk);
    tx_start = 1'b0;
    chk(acc_cnt == a0 && !job_valid, "R10", acc_cnt, a0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule